// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

This block merges device interrupt sources into processor interrupt lines through two stages. The first stage is a mappable group. Its eight status bits track their source lines by level. Two map masks select which of those bits reach a reserved bit in each of the two local groups. The second stage has two local groups. Each local group holds eight status bits, set and cleared by pulse inputs, and an eight-bit mask. Each local group drives one output line. Two timer interrupt outputs latch on a rising edge of their timer inputs and stay high until software clears them.

Software reaches every register through a word-indexed port with 32-bit data. Only the low byte carries meaning. Masks are writable, status registers are read-only, and one write-only offset clears the timer outputs. By convention, the keyboard controller drives mappable bit 4 (0x10) and the serial controller drives mappable bit 5 (0x20).

Top module: `irq_cascade`

## Requirements
- R1: `irq_l0` is high exactly when (local0 mask AND local0 status) is non-zero, and likewise `irq_l1` for local1. The line follows the registers with no further delay, so a change made at a clock edge shows on the line after that edge.
- R2: At each clock edge, a local status bit becomes 1 where its `*_set` bit is 1 and becomes 0 where its `*_clr` bit is 1. If both are 1 for the same bit, set wins. The reserved bits (local0 bit 2, local1 bit 3) ignore `*_set` and `*_clr`.
- R3: At every clock edge, the mappable status register loads the level of `map_src`, so a bit reads 1 while its source is high and 0 after the source goes low.
- R4: Local0 status bit 2 reads 1 exactly when (map mask0 AND mappable status) is non-zero. Local1 status bit 3 reads 1 exactly when (map mask1 AND mappable status) is non-zero.
- R5: A map-mask write changes `irq_l0` / `irq_l1` in the cycle right after the write edge.
- R6: A 0-to-1 change on `tmr_in[i]` between two edges sets `irq_tmr[i]` at the second edge. The output then holds until it is cleared.
- R7: A write to offset 7 clears `irq_tmr[i]` where data bit i is 1 and leaves it unchanged where data bit i is 0. If a rising edge arrives in the same cycle as its clear, the output stays set.
- R8: A mask write (offsets 1, 3, 5, 6) stores `reg_wdata[7:0]`. Bits 31:8 are dropped and read back as 0.
- R9: The read map is combinational by word offset: 0 local0 status, 1 local0 mask, 2 local1 status, 3 local1 mask, 4 mappable status, 5 map mask0, 6 map mask1, 7 reads 0. Read data is zero-extended to 32 bits.
- R10: Writes to offsets 0, 2 and 4 have no effect on any status register.
- R11: While `rst_n` is low, every register reads 0 and every output line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Word offset of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| l0_set | input | 8 | Local0 source raise pulses |
| l0_clr | input | 8 | Local0 source lower pulses |
| l1_set | input | 8 | Local1 source raise pulses |
| l1_clr | input | 8 | Local1 source lower pulses |
| map_src | input | 8 | Mappable source levels |
| tmr_in | input | 2 | Timer event lines |
| irq_l0 | output | 1 | Local0 interrupt line |
| irq_l1 | output | 1 | Local1 interrupt line |
| irq_tmr | output | 2 | Latched timer interrupt lines |

## Verification
Two pairs of functions can fall in the same cycle.

- **Timer rising edge with its clear write.** The bench raises `tmr_in` in the same cycle as a clear write to offset 7 with both data bits set. It expects `irq_tmr` to stay high afterward (R7).
- **Local set with clear on the same bit.** The bench pulses all-ones on `l0_set` and `l0_clr` together. It expects the status to read all ones except the reserved bit (R2).

The random phase also produces these collisions, together with status writes and mask writes. Every result is judged against a register-level model kept in the bench.

// File: rtl/irq_cascade.sv
module irq_cascade #(
  parameter int GW = 8,
  parameter int AW = 3,
  parameter int DW = 32,
  parameter int TN = 2,
  parameter int MAP_BIT0 = 2,
  parameter int MAP_BIT1 = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [GW-1:0] l0_set,
  input  logic [GW-1:0] l0_clr,
  input  logic [GW-1:0] l1_set,
  input  logic [GW-1:0] l1_clr,
  input  logic [GW-1:0] map_src,
  input  logic [TN-1:0] tmr_in,
  output logic          irq_l0,
  output logic          irq_l1,
  output logic [TN-1:0] irq_tmr
);
  localparam logic [AW-1:0] A_L0S = 3'd0, A_L0M = 3'd1, A_L1S = 3'd2, A_L1M = 3'd3,
                            A_MPS = 3'd4, A_MM0 = 3'd5, A_MM1 = 3'd6, A_TCL = 3'd7;
  localparam logic [GW-1:0] ONE  = {{(GW-1){1'b0}}, 1'b1};
  localparam logic [GW-1:0] RES0 = ONE << MAP_BIT0;
  localparam logic [GW-1:0] RES1 = ONE << MAP_BIT1;

  logic [GW-1:0] l0_st, l0_mask, l1_st, l1_mask, map_st, map_m0, map_m1;
  logic [GW-1:0] l0_view, l1_view;
  logic [TN-1:0] tmr_q, tmr_clr;
  logic          map_hit0, map_hit1;

  assign map_hit0 = |(map_m0 & map_st);
  assign map_hit1 = |(map_m1 & map_st);
  assign l0_view  = (l0_st & ~RES0) | (map_hit0 ? RES0 : '0);
  assign l1_view  = (l1_st & ~RES1) | (map_hit1 ? RES1 : '0);
  assign irq_l0   = |(l0_mask & l0_view);
  assign irq_l1   = |(l1_mask & l1_view);
  assign tmr_clr  = (reg_we && reg_addr == A_TCL) ? reg_wdata[TN-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l0_st   <= '0;
      l1_st   <= '0;
      map_st  <= '0;
      tmr_q   <= '0;
      irq_tmr <= '0;
    end else begin
      l0_st   <= ((l0_st & ~l0_clr) | l0_set) & ~RES0;
      l1_st   <= ((l1_st & ~l1_clr) | l1_set) & ~RES1;
      map_st  <= map_src;
      tmr_q   <= tmr_in;
      irq_tmr <= (irq_tmr & ~tmr_clr) | (tmr_in & ~tmr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l0_mask <= '0;
      l1_mask <= '0;
      map_m0  <= '0;
      map_m1  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_L0M:   l0_mask <= reg_wdata[GW-1:0];
        A_L1M:   l1_mask <= reg_wdata[GW-1:0];
        A_MM0:   map_m0  <= reg_wdata[GW-1:0];
        A_MM1:   map_m1  <= reg_wdata[GW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_L0S:   reg_rdata[GW-1:0] = l0_view;
      A_L0M:   reg_rdata[GW-1:0] = l0_mask;
      A_L1S:   reg_rdata[GW-1:0] = l1_view;
      A_L1M:   reg_rdata[GW-1:0] = l1_mask;
      A_MPS:   reg_rdata[GW-1:0] = map_st;
      A_MM0:   reg_rdata[GW-1:0] = map_m0;
      A_MM1:   reg_rdata[GW-1:0] = map_m1;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
  parameter int GW = 8,
  parameter int AW = 3,
  parameter int DW = 32,
  parameter int TN = 2,
  parameter int MAP_BIT0 = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_we,
  input logic [DW-1:0] reg_wdata,
  input logic [GW-1:0] l0_set,
  input logic [GW-1:0] l0_clr,
  input logic [GW-1:0] l0_st,
  input logic [GW-1:0] l0_mask,
  input logic [GW-1:0] map_src,
  input logic [GW-1:0] map_st,
  input logic [TN-1:0] tmr_in,
  input logic [TN-1:0] tmr_q,
  input logic          irq_l0,
  input logic [TN-1:0] irq_tmr
);
  localparam logic [GW-1:0] RES0 = {{(GW-1){1'b0}}, 1'b1} << MAP_BIT0;

  // R1
  l0_line_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_l0 |-> (l0_mask != '0));

  // R2
  l0_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(l0_set & ~RES0)) |=> ((l0_st & $past(l0_set & ~RES0)) == $past(l0_set & ~RES0)));

  // R10
  l0_status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l0_set == '0 && l0_clr == '0) |=> $stable(l0_st));

  // R3
  map_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (map_st == $past(map_src)));

  // R8
  l0_mask_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd1) |=> (l0_mask == $past(reg_wdata[GW-1:0])));

  // R6
  tmr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_in[0] && !tmr_q[0]) |=> irq_tmr[0]);

  // R7
  tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd7 && reg_wdata[0] && !(tmr_in[0] && !tmr_q[0])) |=> !irq_tmr[0]);
endmodule

bind irq_cascade irq_cascade_chk #(.GW(GW), .AW(AW), .DW(DW), .TN(TN), .MAP_BIT0(MAP_BIT0)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .l0_set(l0_set), .l0_clr(l0_clr), .l0_st(l0_st), .l0_mask(l0_mask),
  .map_src(map_src), .map_st(map_st), .tmr_in(tmr_in), .tmr_q(tmr_q),
  .irq_l0(irq_l0), .irq_tmr(irq_tmr));

// File: tb/sim_irq_cascade.sv
module sim_irq_cascade;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  l0_set = '0, l0_clr = '0, l1_set = '0, l1_clr = '0, map_src = '0;
  logic [1:0]  tmr_in = '0;
  logic        irq_l0, irq_l1;
  logic [1:0]  irq_tmr;

  int total = 0, bad = 0;
  bit done = 0;
  string cur = "R11";

  logic [7:0] m_l0s = '0, m_l0m = '0, m_l1s = '0, m_l1m = '0, m_mps = '0, m_mm0 = '0, m_mm1 = '0;
  logic [1:0] m_tq = '0, m_tirq = '0;

  always #10 clk = ~clk;

  irq_cascade u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .l0_set(l0_set), .l0_clr(l0_clr), .l1_set(l1_set), .l1_clr(l1_clr),
    .map_src(map_src), .tmr_in(tmr_in), .irq_l0(irq_l0), .irq_l1(irq_l1), .irq_tmr(irq_tmr));

  function automatic logic [7:0] view0();
    return (m_l0s & 8'hFB) | ((|(m_mm0 & m_mps)) ? 8'h04 : 8'h00);
  endfunction

  function automatic logic [7:0] view1();
    return (m_l1s & 8'hF7) | ((|(m_mm1 & m_mps)) ? 8'h08 : 8'h00);
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {24'h0, view0()};
      3'd1: return {24'h0, m_l0m};
      3'd2: return {24'h0, view1()};
      3'd3: return {24'h0, m_l1m};
      3'd4: return {24'h0, m_mps};
      3'd5: return {24'h0, m_mm0};
      3'd6: return {24'h0, m_mm1};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s [%s] got=%h exp=%h", req, cur, got, exp);
    end
  endtask

  task automatic check_now();
    #1;
    chk("R1", {31'h0, irq_l0}, {31'h0, |(m_l0m & view0())});
    chk("R1", {31'h0, irq_l1}, {31'h0, |(m_l1m & view1())});
    chk("R6", {30'h0, irq_tmr}, {30'h0, m_tirq});
    chk("R9", reg_rdata, exp_read(reg_addr));
  endtask

  task automatic step();
    logic [7:0] n_l0s, n_l1s, n_l0m, n_l1m, n_mm0, n_mm1;
    logic [1:0] n_tirq, clr;
    check_now();
    n_l0s = ((m_l0s & ~l0_clr) | l0_set) & 8'hFB;
    n_l1s = ((m_l1s & ~l1_clr) | l1_set) & 8'hF7;
    n_l0m = m_l0m; n_l1m = m_l1m; n_mm0 = m_mm0; n_mm1 = m_mm1;
    clr = 2'b00;
    if (reg_we) begin
      case (reg_addr)
        3'd1: n_l0m = reg_wdata[7:0];
        3'd3: n_l1m = reg_wdata[7:0];
        3'd5: n_mm0 = reg_wdata[7:0];
        3'd6: n_mm1 = reg_wdata[7:0];
        3'd7: clr = reg_wdata[1:0];
        default: ;
      endcase
    end
    n_tirq = (m_tirq & ~clr) | (tmr_in & ~m_tq);
    @(posedge clk);
    m_l0s = n_l0s; m_l1s = n_l1s; m_l0m = n_l0m; m_l1m = n_l1m;
    m_mm0 = n_mm0; m_mm1 = n_mm1; m_mps = map_src; m_tq = tmr_in; m_tirq = n_tirq;
    @(negedge clk);
  endtask

  task automatic idle();
    reg_we = 0; l0_set = '0; l0_clr = '0; l1_set = '0; l1_clr = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    idle(); reg_addr = a; reg_we = 1; reg_wdata = d; step(); reg_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog [%s] got=running exp=done", cur);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    // R11: reset state, every offset
    cur = "R11";
    l0_set = 8'hFF; map_src = 8'hFF; tmr_in = 2'b11;
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #1;
      chk("R11", reg_rdata, 32'h0);
    end
    chk("R11", {29'h0, irq_l0, irq_tmr}, 32'h0);
    tmr_in = 2'b00; map_src = '0; l0_set = '0;
    @(negedge clk); rst_n = 1; m_tq = 2'b00;

    // R8: upper data bits dropped on mask write
    cur = "R8";
    wr(3'd1, 32'hA5A5_3C81);
    reg_addr = 3'd1; step();

    // R2: set and clear on the same bits, set wins; reserved bit ignores set
    cur = "R2";
    idle(); l0_set = 8'hFF; l0_clr = 8'hFF; step();
    idle(); reg_addr = 3'd0; step();
    idle(); l0_clr = 8'h0F; step();

    // R10: status write ignored
    cur = "R10";
    wr(3'd0, 32'h0000_00FF);
    wr(3'd2, 32'h0000_00FF);
    wr(3'd4, 32'h0000_00FF);
    reg_addr = 3'd0; step();

    // R3 / R4 / R5: keyboard (bit 4) and serial (bit 5) levels through map masks
    cur = "R4";
    wr(3'd3, 32'h08);
    map_src = 8'h10; reg_addr = 3'd4; step();
    reg_addr = 3'd2; step();
    cur = "R5";
    wr(3'd6, 32'h30);
    reg_addr = 3'd2; step();
    cur = "R3";
    map_src = 8'h20; step();
    map_src = 8'h00; step();
    reg_addr = 3'd4; step();

    // R6 / R7: rise sets, clear drops, rise during clear keeps it set
    cur = "R6";
    tmr_in = 2'b01; step();
    tmr_in = 2'b00; step();
    cur = "R7";
    wr(3'd7, 32'h2);
    wr(3'd7, 32'h1);
    step();
    tmr_in = 2'b11; wr(3'd7, 32'h3);
    step();
    tmr_in = 2'b00; wr(3'd7, 32'h3);
    step();

    // random phase, all requirements against the model
    cur = "R1 random";
    for (int i = 0; i < 3000; i++) begin
      reg_addr  = 3'($urandom_range(0, 7));
      reg_we    = ($urandom_range(0, 3) == 0);
      reg_wdata = $urandom();
      l0_set    = 8'($urandom() & $urandom() & $urandom());
      l0_clr    = 8'($urandom() & $urandom() & $urandom());
      l1_set    = 8'($urandom() & $urandom() & $urandom());
      l1_clr    = 8'($urandom() & $urandom() & $urandom());
      if ($urandom_range(0, 7) == 0) map_src = 8'($urandom());
      if ($urandom_range(0, 3) == 0) tmr_in = 2'($urandom());
      step();
    end
    idle(); step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule